// File: doc/BRIEF.md
# Flagged Integer ALU

A purely combinational arithmetic and logic unit for a datapath of parameterised width. A three-bit operation code picks one of seven functions: addition, subtraction, bitwise AND, bitwise OR, signed set-less-than, logical shift left and logical shift right. The result comes with four condition flags: negative, zero, carry and signed overflow.

Addition, subtraction and the comparison all use one shared adder. For subtraction the adder takes the bitwise inverse of the second operand with a forced carry-in of one. Set-less-than reads the sign and overflow of that same subtraction. Both shifts take their distance from the low log2(width) bits of the second operand, and the barrel shifter is built from one stage per distance bit.

The block has no clock and no state. The outputs follow the inputs through combinational logic only, so the operation code and operands are plain control inputs with no handshake.

Top module: `flag_alu`

## Requirements
- R1: Code 000 (add) gives result = (A + B) mod 2^W. C is the carry out of the most significant bit.
- R2: Code 001 (subtract) gives result = (A - B) mod 2^W, formed as A + ~B + 1. C is the carry out of that sum, so C = 1 exactly when A >= B taken as unsigned values.
- R3: For add and subtract, V = 1 exactly when the two adder inputs (A and B for add, A and ~B for subtract) share a sign and the result sign differs from it. Otherwise V = 0.
- R4: Code 010 gives A AND B. Code 011 gives A OR B. Both work bit by bit.
- R5: Code 101 (set-less-than) gives 1 when A < B as two's-complement values, computed as N XOR V of A - B. Otherwise it gives 0. The value is zero-extended to W bits. C and V report that subtraction.
- R6: Code 110 shifts A left and code 111 shifts A right, both logically. The distance is B[log2(W)-1:0], vacated positions fill with zeros, and the higher bits of B have no effect.
- R7: C = 0 and V = 0 for codes 010, 011, 110, 111 and the unused code 100.
- R8: For every code, N equals the result MSB and Z = 1 exactly when every result bit is zero.
- R9: The unused code 100 gives an all-zero result, so Z = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation select code |
| a_i | input | W | First operand; the value shifted by shift codes |
| b_i | input | W | Second operand; its low log2(W) bits give the shift distance |
| res_o | output | W | Operation result |
| neg_o | output | 1 | Negative flag (result MSB) |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Adder carry out, or 0 for non-adder codes |
| ovf_o | output | 1 | Signed overflow, or 0 for non-adder codes |

## Verification
The bench probes where the sign boundary bites.

- Adding two large negatives, a positive to the most positive value, and -128 - 1 all overflow. A design that flagged overflow from the carry instead of the sign rule would report the wrong V.
- Comparing 1 with -128 overflows the subtraction. An ALU that took set-less-than from the raw sign bit would answer wrongly there.
- Subtracting from an equal or smaller value separates a carry polarity that means "no borrow" from one that means "borrow".
- Shift cases use distances with high bits set in B and every distance 0 to W-1. A shifter that used too many distance bits, or filled with the wrong value, would show it.
- The unused code confirms that no stale adder flags leak out.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_NUL = 3'b100,
    OP_SLT = 3'b101,
    OP_SLL = 3'b110,
    OP_SRL = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    // signed overflow: like-signed inputs, result sign flipped
    ovf_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [SW-1:0] dist_i,
  input  logic          right_i,
  output logic [W-1:0]  val_o
);
  logic [W-1:0] stage [SW+1];

  assign stage[0] = val_i;

  // one stage per distance bit, each moving by a power of two
  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    always_comb begin
      if (!dist_i[s])
        stage[s+1] = stage[s];
      else if (right_i)
        stage[s+1] = stage[s] >> STEP;
      else
        stage[s+1] = stage[s] << STEP;
    end
  end

  assign val_o = stage[SW];
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         neg_o,
  output logic         zero_o,
  output logic         carry_o,
  output logic         ovf_o
);
  alu_op_e      op;
  logic         use_sub;
  logic [W-1:0] sum;
  logic         cout;
  logic         ovf;
  logic [W-1:0] shifted;

  assign op      = alu_op_e'(op_i);
  assign use_sub = (op == OP_SUB) || (op == OP_SLT);

  alu_addsub #(.W(W)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (use_sub),
    .sum_o (sum),
    .cout_o(cout),
    .ovf_o (ovf)
  );

  alu_shift #(.W(W)) u_shift (
    .val_i  (a_i),
    .dist_i (b_i[SW-1:0]),
    .right_i(op == OP_SRL),
    .val_o  (shifted)
  );

  always_comb begin
    res_o   = '0;
    carry_o = 1'b0;
    ovf_o   = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        res_o   = sum;
        carry_o = cout;
        ovf_o   = ovf;
      end
      OP_SLT: begin
        res_o   = {{(W-1){1'b0}}, sum[W-1] ^ ovf};
        carry_o = cout;
        ovf_o   = ovf;
      end
      OP_AND:         res_o = a_i & b_i;
      OP_OR:          res_o = a_i | b_i;
      OP_SLL, OP_SRL: res_o = shifted;
      default:        res_o = '0;
    endcase
  end

  assign neg_o  = res_o[W-1];
  assign zero_o = ~|res_o;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W = 32
) (
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] res_o,
  input logic         carry_o,
  input logic         ovf_o
);
  always_comb begin
    if (op_i == 3'b001)
      a_r2_sub_carry: assert (carry_o == (a_i >= b_i))
        else $error("subtract carry mismatch");
    if (op_i == 3'b000 && a_i[W-1] != b_i[W-1])
      a_r3_no_overflow: assert (!ovf_o)
        else $error("overflow on mixed-sign add");
    if (op_i == 3'b101)
      a_r5_slt_bool: assert (res_o[W-1:1] == '0)
        else $error("set-less-than upper bits set");
    if (op_i == 3'b010 || op_i == 3'b011 || op_i == 3'b100 ||
        op_i == 3'b110 || op_i == 3'b111)
      a_r7_cv_clear: assert (!carry_o && !ovf_o)
        else $error("carry/overflow not cleared");
    if (op_i == 3'b100)
      a_r9_null_zero: assert (res_o == '0)
        else $error("unused code result nonzero");
  end
endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
  .op_i   (op_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .res_o  (res_o),
  .carry_o(carry_o),
  .ovf_o  (ovf_o)
);

// File: tb/flag_alu_tb.sv
module flag_alu_tb;
  localparam int W  = 8;
  localparam int NV = 20;

  typedef struct packed {
    logic [2:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] res;
    logic         n;
    logic         z;
    logic         c;
    logic         v;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'b000, 8'h2F, 8'h0B, 8'h3A, 1'b0, 1'b0, 1'b0, 1'b0}, // R1
    '{3'b000, 8'hF0, 8'h20, 8'h10, 1'b0, 1'b0, 1'b1, 1'b0}, // R1 carry
    '{3'b000, 8'h70, 8'h10, 8'h80, 1'b1, 1'b0, 1'b0, 1'b1}, // R3
    '{3'b000, 8'h80, 8'h80, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1}, // R3 R8
    '{3'b001, 8'h2F, 8'h0B, 8'h24, 1'b0, 1'b0, 1'b1, 1'b0}, // R2
    '{3'b001, 8'h0B, 8'h2F, 8'hDC, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 borrow
    '{3'b001, 8'h80, 8'h01, 8'h7F, 1'b0, 1'b0, 1'b1, 1'b1}, // R3
    '{3'b001, 8'h05, 8'h05, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0}, // R2 R8
    '{3'b010, 8'hF0, 8'h3C, 8'h30, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
    '{3'b011, 8'hF0, 8'h0C, 8'hFC, 1'b1, 1'b0, 1'b0, 1'b0}, // R4
    '{3'b101, 8'h80, 8'h01, 8'h01, 1'b0, 1'b0, 1'b1, 1'b1}, // R5
    '{3'b101, 8'h01, 8'h80, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1}, // R5
    '{3'b101, 8'h05, 8'h05, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0}, // R5
    '{3'b101, 8'hFE, 8'hFF, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0}, // R5
    '{3'b110, 8'h81, 8'h0B, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{3'b111, 8'h81, 8'h0F, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{3'b110, 8'h81, 8'h00, 8'h81, 1'b1, 1'b0, 1'b0, 1'b0}, // R6
    '{3'b111, 8'h80, 8'h08, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0}, // R6
    '{3'b100, 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0}, // R9 R7
    '{3'b011, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0}  // R8
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op_i = '0;
  logic [W-1:0] a_i  = '0;
  logic [W-1:0] b_i  = '0;
  logic [W-1:0] res_o;
  logic         neg_o, zero_o, carry_o, ovf_o;
  int           n_chk = 0;
  int           n_bad = 0;
  logic         done  = 1'b0;

  always #4 clk = ~clk;

  flag_alu #(.W(W)) u_dut (
    .op_i   (op_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .res_o  (res_o),
    .neg_o  (neg_o),
    .zero_o (zero_o),
    .carry_o(carry_o),
    .ovf_o  (ovf_o)
  );

  task automatic apply(input logic [2:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b);
    @(posedge clk);
    op_i = op;
    a_i  = a;
    b_i  = b;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [W-1:0] er,
                       input logic en, input logic ez, input logic ec,
                       input logic ev);
    n_chk++;
    if (res_o !== er || neg_o !== en || zero_o !== ez ||
        carry_o !== ec || ovf_o !== ev) begin
      n_bad++;
      $display("FAIL %s op=%b a=%h b=%h: got res=%h nzcv=%b%b%b%b exp res=%h nzcv=%b%b%b%b",
               tag, op_i, a_i, b_i, res_o, neg_o, zero_o, carry_o, ovf_o,
               er, en, ez, ec, ev);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // idle state: zero inputs, add code (R8)
    @(negedge clk);
    check("R8 idle", 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b);
      check($sformatf("vec%0d R1-9 table", i), VECS[i].res, VECS[i].n,
            VECS[i].z, VECS[i].c, VECS[i].v);
    end

    // R6: every distance, both directions, junk in upper distance bits
    for (int k = 0; k < W; k++) begin
      logic [W-1:0] el, er;
      el = 8'hA5 << k;
      er = 8'hA5 >> k;
      apply(3'b110, 8'hA5, 8'(k) | 8'hF8);
      check("R6 sll sweep", el, el[W-1], el == 0, 1'b0, 1'b0);
      apply(3'b111, 8'hA5, 8'(k) | 8'hF8);
      check("R6 srl sweep", er, er[W-1], er == 0, 1'b0, 1'b0);
    end

    // R7 after an overflowing add, logical op must clear C and V
    apply(3'b000, 8'h80, 8'h80);
    apply(3'b010, 8'h80, 8'h80);
    check("R7 and after ovf", 8'h80, 1'b1, 1'b0, 1'b0, 1'b0);

    // R3 most positive plus one
    apply(3'b000, 8'h7F, 8'h01);
    check("R3 max+1", 8'h80, 1'b1, 1'b0, 1'b0, 1'b1);

    // R5 most negative against most positive
    apply(3'b101, 8'h80, 8'h7F);
    check("R5 min<max", 8'h01, 1'b0, 1'b0, 1'b1, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule